// File: doc/BRIEF.md
# Eight-Channel Match Timer with Shared Counters

This block holds eight match channels, numbered 4 to 11. Each channel has a 32-bit counter, a 32-bit match value and a control word. A channel's counter advances on one of four externally generated tick enables, chosen by a rate code in its control word. A channel can also borrow the counter of a leader channel instead of running its own. When the counter a channel watches steps onto that channel's match value, the channel fires. A firing channel can zero that counter. It either re-arms for the next pass or stays silent until software touches it again. Fired channels whose interrupt enable is set raise status bits 4 to 11, and any set status bit holds one combined interrupt line high.

Software reaches the block through a simple single-cycle register port with byte addresses. Reads are combinational and writes take effect at the next clock edge. Reading the counter of channel 9 or 11 can copy the counter of its partner, channel 8 or 10, into a snapshot register, so that two counters can be sampled together.

Top module: `tmx_ext_timer`

## Requirements
- R1: Registers sit at these byte addresses, with k = channel - 4: match at 0x80+4k, counter at 0x40+4k, control at 0xC0+4k, snapshot at 0x20, status at 0x14, interrupt enable at 0x1C. After reset every register, counter and the interrupt read zero.
- R2: The rate code is control bits 2:0. Code 1 steps on tick_en[0], code 2 on tick_en[1], code 3 on tick_en[2] and code 4 on tick_en[3]. Codes 0, 5, 6 and 7 stop the counter.
- R3: A control write keeps bits 7:0 on channels 4 to 7 and bits 9:0 on channels 8 to 11. All other bits read zero. The enable register keeps only bits 11:4.
- R4: When control bit 7 is clear, channels 5, 6 and 7 compare against channel 4's counter, channel 9 against channel 8's and channel 11 against channel 10's, and their own counters hold. Channels 4, 8 and 10 always use their own counter.
- R5: On channels 8 to 11, control bit 8 set stops the counter regardless of the rate code.
- R6: A counter advances by one on each cycle its selected tick enable is high and wraps from 0xFFFFFFFF to 0. A write loads the written value, and a write takes priority over a step in the same cycle.
- R7: A hit is a step of the watched counter onto the match value. With control bit 6 set every hit fires. Otherwise a hit fires only while the channel is armed. Writing the channel's match or counter register arms it, and any hit disarms it.
- R8: When a channel with control bit 3 set fires, the watched counter loads 0 in place of the match value. A hit that does not fire leaves the counter at the match value.
- R9: A firing channel sets its status bit (bit 4+k) only if its enable bit 4+k is set. Writing 1 to a status bit clears it.
- R10: irq is high while any status bit 11:4 is set, and falls only after a status write clears the last set bit.
- R11: A read of the counter at 0x54 or 0x5C while that channel's control bit 9 is set copies the counter of channel 8 or 10 into the snapshot register at the clock edge that ends the read. No other event changes the snapshot register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | TICK_N (4) | Rate tick enables: 32768 Hz, 1 kHz, 1 Hz, 1 MHz |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | AW (8) | Byte address |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data, valid in the cycle bus_rd is high |
| irq | output | 1 | Combined channel interrupt |

## Verification
The assertions take the register port as single-cycle and well formed. They expect an address to be stable while its strobe is high, and reads and writes never to share a cycle. They also treat tick enables as level inputs sampled at each edge, with any number of rates active together. The stimulus drives every strobe and tick for whole cycles, changes them on the falling edge, and never raises bus_wr and bus_rd together. Tick enables stay low except in dedicated stepping cycles, so each counter value the bench expects follows from an exact count of the ticks it drove.

// File: rtl/tmx_pkg.sv
package tmx_pkg;
    // channel group layout
    localparam int CH_N    = 8;
    localparam int STAT_LO = 4;

    // register byte offsets (channel k = channel number - 4)
    localparam int OFS_MATCH = 'h80;
    localparam int OFS_COUNT = 'h40;
    localparam int OFS_CTRL  = 'hC0;
    localparam int OFS_SNAP  = 'h20;
    localparam int OFS_STAT  = 'h14;
    localparam int OFS_IEN   = 'h1C;

    // control word layout
    localparam int RATE_W   = 3;
    localparam int NARROW_W = 8;
    localparam int CTRL_W   = 10;
    localparam int B_RESET  = 3;
    localparam int B_REPEAT = 6;
    localparam int B_OWN    = 7;
    localparam int B_SYNC   = 8;
    localparam int B_SNAP   = 9;

    // lower half: index 0 leads the group; upper half: even index leads its pair
    function automatic int leader_of(input int idx);
        return (idx < CH_N / 2) ? 0 : (idx & ~1);
    endfunction
endpackage

// File: rtl/tmx_rate_sel.sv
module tmx_rate_sel #(
    parameter int TICK_N = 4,
    parameter int CODE_W = 3
) (
    input  logic [CODE_W-1:0] code,
    input  logic              force_stop,
    input  logic [TICK_N-1:0] tick_en,
    output logic              step
);
    // code k+1 selects tick_en[k]; every other code is a stop
    always_comb begin
        step = 1'b0;
        for (int k = 0; k < TICK_N; k++) begin
            if (code == CODE_W'(k + 1)) begin
                step = tick_en[k];
            end
        end
        if (force_stop) begin
            step = 1'b0;
        end
    end
endmodule

// File: rtl/tmx_counter.sv
module tmx_counter #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    input  logic          step,
    input  logic          clear,
    output logic [DW-1:0] cnt_q,
    output logic [DW-1:0] cnt_inc
);
    logic [DW-1:0] cnt_d;

    always_comb begin
        cnt_inc = cnt_q + DW'(1);
        cnt_d   = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (step) begin
            cnt_d = clear ? '0 : cnt_inc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/tmx_match.sv
module tmx_match #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          src_step,
    input  logic [DW-1:0] src_next,
    input  logic [DW-1:0] match_val,
    input  logic          periodic,
    input  logic          arm_set,
    output logic          hit,
    output logic          fire,
    output logic          armed_q
);
    logic armed_d;

    always_comb begin
        hit     = src_step && (src_next == match_val);
        fire    = hit && (periodic || armed_q);
        armed_d = armed_q;
        if (arm_set) begin
            armed_d = 1'b1;
        end else if (hit) begin
            armed_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else begin
            armed_q <= armed_d;
        end
    end
endmodule

// File: rtl/tmx_ext_timer.sv
module tmx_ext_timer
    import tmx_pkg::*;
#(
    parameter int DW     = 32,
    parameter int TICK_N = 4,
    parameter int AW     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TICK_N-1:0] tick_en,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              irq
);
    localparam int HALF = CH_N / 2;

    typedef struct packed {
        logic [CH_N-1:0][DW-1:0]     match;
        logic [CH_N-1:0][CTRL_W-1:0] ctrl;
        logic [CH_N-1:0]             stat;
        logic [CH_N-1:0]             ien;
        logic [DW-1:0]               snap;
    } regs_t;

    regs_t r_q, r_d;

    logic [CH_N-1:0][CTRL_W-1:0] ctrl_q;
    logic [CH_N-1:0]             stat_q;
    logic [CH_N-1:0]             ien_q;
    logic [DW-1:0]               snap_q;

    logic [CH_N-1:0]         wr_match, wr_count, wr_ctrl, rd_count;
    logic                    wr_stat, wr_ien;
    logic [CH_N-1:0]         shared, stop_rq, own_step, src_step;
    logic [CH_N-1:0]         hit, fire, armed, zero_req;
    logic [CH_N-1:0][DW-1:0] cnt_q, cnt_inc, src_next;
    logic [CH_N-1:0]         stat_clr;

    assign ctrl_q = r_q.ctrl;
    assign stat_q = r_q.stat;
    assign ien_q  = r_q.ien;
    assign snap_q = r_q.snap;

    function automatic logic [AW-1:0] slot(input int base, input int idx);
        return AW'(base + 4 * idx);
    endfunction

    // address decode
    always_comb begin
        for (int i = 0; i < CH_N; i++) begin
            wr_match[i] = bus_wr && (bus_addr == slot(OFS_MATCH, i));
            wr_count[i] = bus_wr && (bus_addr == slot(OFS_COUNT, i));
            wr_ctrl[i]  = bus_wr && (bus_addr == slot(OFS_CTRL, i));
            rd_count[i] = bus_rd && (bus_addr == slot(OFS_COUNT, i));
        end
        wr_stat = bus_wr && (bus_addr == AW'(OFS_STAT));
        wr_ien  = bus_wr && (bus_addr == AW'(OFS_IEN));
    end

    // per-channel datapath
    for (genvar i = 0; i < CH_N; i++) begin : g_ch
        localparam int LEAD   = leader_of(i);
        localparam bit FOLLOW = (LEAD != i);
        localparam bit WIDE   = (i >= HALF);

        assign shared[i]  = FOLLOW && !ctrl_q[i][B_OWN];
        assign stop_rq[i] = shared[i] || (WIDE && ctrl_q[i][B_SYNC]);

        tmx_rate_sel #(
            .TICK_N (TICK_N),
            .CODE_W (RATE_W)
        ) u_rate (
            .code       (ctrl_q[i][RATE_W-1:0]),
            .force_stop (stop_rq[i]),
            .tick_en    (tick_en),
            .step       (own_step[i])
        );

        tmx_counter #(
            .DW (DW)
        ) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (wr_count[i]),
            .load_val (bus_wdata),
            .step     (own_step[i]),
            .clear    (zero_req[i]),
            .cnt_q    (cnt_q[i]),
            .cnt_inc  (cnt_inc[i])
        );

        assign src_step[i] = shared[i] ? own_step[LEAD] : own_step[i];
        assign src_next[i] = shared[i] ? cnt_inc[LEAD]  : cnt_inc[i];

        tmx_match #(
            .DW (DW)
        ) u_match (
            .clk       (clk),
            .rst_n     (rst_n),
            .src_step  (src_step[i]),
            .src_next  (src_next[i]),
            .match_val (r_q.match[i]),
            .periodic  (ctrl_q[i][B_REPEAT]),
            .arm_set   (wr_match[i] || wr_count[i]),
            .hit       (hit[i]),
            .fire      (fire[i]),
            .armed_q   (armed[i])
        );
    end

    // reset-on-match: a firing channel zeroes whichever counter it watches
    always_comb begin
        zero_req = '0;
        for (int i = 0; i < CH_N; i++) begin
            if (fire[i] && ctrl_q[i][B_RESET]) begin
                zero_req[shared[i] ? leader_of(i) : i] = 1'b1;
            end
        end
    end

    // next register state
    always_comb begin
        r_d = r_q;
        for (int i = 0; i < CH_N; i++) begin
            if (wr_match[i]) begin
                r_d.match[i] = bus_wdata;
            end
            if (wr_ctrl[i]) begin
                if (i < HALF) begin
                    r_d.ctrl[i] = CTRL_W'(bus_wdata[NARROW_W-1:0]);
                end else begin
                    r_d.ctrl[i] = bus_wdata[CTRL_W-1:0];
                end
            end
        end
        if (wr_ien) begin
            r_d.ien = bus_wdata[STAT_LO +: CH_N];
        end
        stat_clr  = wr_stat ? bus_wdata[STAT_LO +: CH_N] : '0;
        r_d.stat  = (r_q.stat & ~stat_clr) | (fire & r_q.ien);
        for (int i = HALF + 1; i < CH_N; i += 2) begin
            if (rd_count[i] && ctrl_q[i][B_SNAP]) begin
                r_d.snap = cnt_q[i-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < CH_N; i++) begin
            if (bus_addr == slot(OFS_MATCH, i)) bus_rdata = r_q.match[i];
            if (bus_addr == slot(OFS_COUNT, i)) bus_rdata = cnt_q[i];
            if (bus_addr == slot(OFS_CTRL, i))  bus_rdata = DW'(ctrl_q[i]);
        end
        if (bus_addr == AW'(OFS_STAT)) bus_rdata = DW'({stat_q, {STAT_LO{1'b0}}});
        if (bus_addr == AW'(OFS_IEN))  bus_rdata = DW'({ien_q, {STAT_LO{1'b0}}});
        if (bus_addr == AW'(OFS_SNAP)) bus_rdata = snap_q;
    end

    assign irq = |stat_q;
endmodule

// File: rtl/tmx_ext_timer_chk.sv
module tmx_ext_timer_chk
    import tmx_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        bus_wr,
    input logic                        bus_rd,
    input logic [AW-1:0]               bus_addr,
    input logic [DW-1:0]               bus_wdata,
    input logic                        irq,
    input logic [CH_N-1:0][CTRL_W-1:0] ctrl_v,
    input logic [CH_N-1:0][DW-1:0]     cnt_v,
    input logic [CH_N-1:0]             own_step,
    input logic [CH_N-1:0]             wr_count,
    input logic [CH_N-1:0]             zero_req,
    input logic [CH_N-1:0]             hit,
    input logic [CH_N-1:0]             armed,
    input logic [CH_N-1:0]             stat_v,
    input logic [CH_N-1:0]             ien_v,
    input logic [DW-1:0]               snap_v
);
    localparam int WIDE0 = CH_N / 2;

    assert_ctrl_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AW'(OFS_CTRL))
        |=> ctrl_v[0] == CTRL_W'($past(bus_wdata[NARROW_W-1:0])));

    assert_sync_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_v[WIDE0][B_SYNC] && !wr_count[WIDE0])
        |=> cnt_v[WIDE0] == $past(cnt_v[WIDE0]));

    for (genvar i = 0; i < CH_N; i++) begin : g_prop
        assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (own_step[i] && !wr_count[i] && !zero_req[i])
            |=> cnt_v[i] == $past(cnt_v[i]) + DW'(1));

        assert_disarm_on_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(armed[i]) |-> $past(hit[i]));
    end

    assert_stat_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> ((stat_v & ~$past(stat_v) & ~$past(ien_v)) == '0));

    assert_irq_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(bus_wr && bus_addr == AW'(OFS_STAT)));

    assert_snap_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(snap_v)
        |-> $past(bus_rd && (bus_addr == AW'(OFS_COUNT + 4 * 5) || bus_addr == AW'(OFS_COUNT + 4 * 7))));
endmodule

bind tmx_ext_timer tmx_ext_timer_chk #(
    .DW (DW),
    .AW (AW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .ctrl_v    (ctrl_q),
    .cnt_v     (cnt_q),
    .own_step  (own_step),
    .wr_count  (wr_count),
    .zero_req  (zero_req),
    .hit       (hit),
    .armed     (armed),
    .stat_v    (stat_q),
    .ien_v     (ien_q),
    .snap_v    (snap_q)
);

// File: tb/sim_tmx_ext_timer.sv
`timescale 1ns/1ps
module sim_tmx_ext_timer;
    localparam int DW = 32;
    localparam int AW = 8;
    localparam int TN = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [TN-1:0] tick_en;
    logic          bus_wr, bus_rd;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata;
    logic          irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    tmx_ext_timer #(.DW(DW), .TICK_N(TN), .AW(AW)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    localparam logic [1:0] OW = 2'd0, ORD = 2'd1, OTK = 2'd2, OIQ = 2'd3;

    typedef struct packed {
        logic [1:0]  op;
        logic [7:0]  addr;   // tick ops: number of cycles
        logic [31:0] data;   // tick ops: tick_en mask
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 82;
    localparam vec_t VT [NV] = '{
        '{ORD, 8'h14, 32'h0,        32'h0,     4'd1},   // R1 status after reset
        '{OIQ, 8'h00, 32'h0,        32'h0,     4'd10},  // R10 irq low
        '{ORD, 8'hC0, 32'h0,        32'h0,     4'd1},   // R1 control after reset
        '{OW,  8'h1C, 32'hFFFFFFFF, 32'h0,     4'd0},
        '{ORD, 8'h1C, 32'h0,        32'hFF0,   4'd3},   // R3 enable mask
        '{OW,  8'hC0, 32'hFFFFFFFF, 32'h0,     4'd0},
        '{ORD, 8'hC0, 32'h0,        32'hFF,    4'd3},   // R3 narrow control
        '{OW,  8'hD0, 32'hFFFFFFFF, 32'h0,     4'd0},
        '{ORD, 8'hD0, 32'h0,        32'h3FF,   4'd3},   // R3 wide control
        '{OW,  8'hD0, 32'h0,        32'h0,     4'd0},
        '{OW,  8'hC0, 32'h09,       32'h0,     4'd0},   // ch4 one-shot, reset, rate 1
        '{OW,  8'h80, 32'h2,        32'h0,     4'd0},
        '{OW,  8'h40, 32'h0,        32'h0,     4'd0},
        '{OTK, 8'd1,  32'h1,        32'h0,     4'd0},
        '{ORD, 8'h40, 32'h0,        32'h1,     4'd6},   // R6 step by one
        '{ORD, 8'h14, 32'h0,        32'h0,     4'd7},   // R7 no hit yet
        '{OTK, 8'd1,  32'h1,        32'h0,     4'd0},
        '{ORD, 8'h40, 32'h0,        32'h0,     4'd8},   // R8 zeroed on fire
        '{ORD, 8'h14, 32'h0,        32'h10,    4'd7},   // R7 one-shot fired
        '{OIQ, 8'h00, 32'h0,        32'h1,     4'd10},  // R10
        '{OW,  8'h14, 32'h10,       32'h0,     4'd0},
        '{ORD, 8'h14, 32'h0,        32'h0,     4'd9},   // R9 write-one clear
        '{OIQ, 8'h00, 32'h0,        32'h0,     4'd10},  // R10 dropped
        '{OTK, 8'd2,  32'h1,        32'h0,     4'd0},
        '{ORD, 8'h40, 32'h0,        32'h2,     4'd8},   // R8 no zero without fire
        '{ORD, 8'h14, 32'h0,        32'h0,     4'd7},   // R7 disarmed
        '{OTK, 8'd3,  32'hE,        32'h0,     4'd0},
        '{ORD, 8'h40, 32'h0,        32'h2,     4'd2},   // R2 other rates ignored
        '{OW,  8'hC0, 32'h49,       32'h0,     4'd0},   // periodic
        '{OW,  8'h40, 32'h0,        32'h0,     4'd0},
        '{OTK, 8'd2,  32'h1,        32'h0,     4'd0},
        '{ORD, 8'h14, 32'h0,        32'h10,    4'd7},   // R7
        '{OW,  8'h14, 32'h10,       32'h0,     4'd0},
        '{OTK, 8'd2,  32'h1,        32'h0,     4'd0},
        '{ORD, 8'h14, 32'h0,        32'h10,    4'd7},   // R7 periodic refire
        '{ORD, 8'h40, 32'h0,        32'h0,     4'd8},   // R8
        '{OW,  8'h14, 32'h10,       32'h0,     4'd0},
        '{OW,  8'h84, 32'h1,        32'h0,     4'd0},   // ch5 follows ch4
        '{OW,  8'hC4, 32'h40,       32'h0,     4'd0},
        '{OW,  8'h44, 32'h55,       32'h0,     4'd0},
        '{OTK, 8'd1,  32'h1,        32'h0,     4'd0},
        '{ORD, 8'h14, 32'h0,        32'h20,    4'd4},   // R4 fired on leader counter
        '{ORD, 8'h44, 32'h0,        32'h55,    4'd4},   // R4 own counter held
        '{ORD, 8'h40, 32'h0,        32'h1,     4'd4},   // R4
        '{OW,  8'h14, 32'h20,       32'h0,     4'd0},
        '{OW,  8'hC4, 32'h84,       32'h0,     4'd0},   // ch5 own, rate 4
        '{OTK, 8'd1,  32'h8,        32'h0,     4'd0},
        '{ORD, 8'h44, 32'h0,        32'h56,    4'd2},   // R2 rate 4
        '{ORD, 8'h40, 32'h0,        32'h1,     4'd2},   // R2 rate 1 idle
        '{OW,  8'hD8, 32'h04,       32'h0,     4'd0},   // ch10
        '{OW,  8'h98, 32'h0,        32'h0,     4'd0},
        '{OW,  8'h58, 32'hFFFFFFFF, 32'h0,     4'd0},
        '{OTK, 8'd1,  32'h8,        32'h0,     4'd0},
        '{ORD, 8'h58, 32'h0,        32'h0,     4'd6},   // R6 wrap
        '{ORD, 8'h14, 32'h0,        32'h400,   4'd6},   // R6 wrap hits match 0
        '{OIQ, 8'h00, 32'h0,        32'h1,     4'd10},  // R10
        '{OW,  8'hD0, 32'h104,      32'h0,     4'd0},   // ch8 sync stop
        '{OW,  8'h50, 32'h5,        32'h0,     4'd0},
        '{OTK, 8'd1,  32'h8,        32'h0,     4'd0},
        '{ORD, 8'h50, 32'h0,        32'h5,     4'd5},   // R5 held
        '{OW,  8'hD0, 32'h04,       32'h0,     4'd0},
        '{OTK, 8'd1,  32'h8,        32'h0,     4'd0},
        '{ORD, 8'h50, 32'h0,        32'h6,     4'd5},   // R5 runs again
        '{OW,  8'h50, 32'h1234,     32'h0,     4'd0},
        '{OW,  8'hD4, 32'h200,      32'h0,     4'd0},
        '{ORD, 8'h54, 32'h0,        32'h0,     4'd11},  // R11 triggering read
        '{ORD, 8'h20, 32'h0,        32'h1234,  4'd11},  // R11 captured
        '{OW,  8'hD4, 32'h0,        32'h0,     4'd0},
        '{OW,  8'h50, 32'h77,       32'h0,     4'd0},
        '{ORD, 8'h54, 32'h0,        32'h0,     4'd11},  // R11 read without bit 9
        '{ORD, 8'h20, 32'h0,        32'h1234,  4'd11},  // R11 unchanged
        '{OW,  8'h1C, 32'hFE0,      32'h0,     4'd0},
        '{OTK, 8'd1,  32'h1,        32'h0,     4'd0},
        '{ORD, 8'h14, 32'h0,        32'h400,   4'd9},   // R9 disabled channel silent
        '{ORD, 8'h40, 32'h0,        32'h0,     4'd8},   // R8 fire still zeroes
        '{OW,  8'h1C, 32'hFF0,      32'h0,     4'd0},
        '{OTK, 8'd2,  32'h1,        32'h0,     4'd0},
        '{OW,  8'h14, 32'h400,      32'h0,     4'd0},
        '{OIQ, 8'h00, 32'h0,        32'h1,     4'd10},  // R10 one bit left
        '{OW,  8'h14, 32'h10,       32'h0,     4'd0},
        '{OIQ, 8'h00, 32'h0,        32'h0,     4'd10},  // R10 all clear
        '{ORD, 8'h14, 32'h0,        32'h0,     4'd10}   // R10
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input int req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_rd(input logic [7:0] a, input logic [31:0] e, input int req);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #2;
        check(bus_rdata, e, req);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic do_tick(input logic [3:0] m, input int n);
        @(negedge clk);
        tick_en = m;
        repeat (n) @(negedge clk);
        tick_en = '0;
    endtask

    task automatic do_irq(input logic e, input int req);
        @(negedge clk);
        #2;
        check({31'b0, irq}, {31'b0, e}, req);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        rst_n = 1'b0; tick_en = '0; bus_wr = 1'b0; bus_rd = 1'b0;
        bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            case (VT[v].op)
                OW:  do_wr(VT[v].addr, VT[v].data);
                ORD: do_rd(VT[v].addr, VT[v].exp, int'(VT[v].req));
                OTK: do_tick(VT[v].data[3:0], int'(VT[v].addr));
                default: do_irq(VT[v].exp[0], int'(VT[v].req));
            endcase
        end

        // directed: raise status, then reset mid-run (R1)
        do_wr(8'hD8, 32'h4C);
        do_wr(8'h98, 32'h3);
        do_wr(8'h58, 32'h0);
        do_tick(4'h8, 3);
        do_irq(1'b1, 10);          // R10 raised by ch10
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        do_irq(1'b0, 1);           // R1 irq cleared by reset
        do_rd(8'h1C, 32'h0, 1);    // R1 enable cleared
        do_rd(8'h58, 32'h0, 1);    // R1 counter cleared
        do_rd(8'hD8, 32'h0, 1);    // R1 control cleared
        do_rd(8'h20, 32'h0, 1);    // R1 snapshot cleared

        // directed: ch10 with code 0 stays still (R2)
        do_tick(4'hF, 4);
        do_rd(8'h58, 32'h0, 2);    // R2 code 0 stops

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R0 watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule